// File: doc/BRIEF.md
# Addressing-Mode Operand Evaluator

This block takes one 16-bit instruction word and resolves its operand. The
three high bits select how the low ten bits, the operand specifier, are read.
The value can be used as it stands. It can also be used as a memory address,
as the address of a pointer word, or as an offset added to the index register
or to the stack pointer. Memory is reached through a read port with a
request/acknowledge handshake. The acknowledge may come after any number of
wait cycles.

A sequencer pulses `start` with the instruction and the low bits of both base
registers. It then waits for `done`. With `done`, the block presents the
operand. For the memory modes it also presents the effective address, so that
a store can write back to that address. Mode codes that have no meaning raise
a flag and make no memory access. Opcode execution and condition codes belong
to other blocks.

The control is a four-state machine:

- **IDLE** waits for `start`. From IDLE:
  - it goes to FINISH for an immediate or illegal mode;
  - it goes to FETCH_PTR for indirect mode;
  - it goes to FETCH_OPND for the direct, indexed and stack modes.
- **FETCH_PTR** holds a read of the pointer word. On acknowledge it goes to FETCH_OPND.
- **FETCH_OPND** holds a read of the operand word. On acknowledge it goes to FINISH.
- **FINISH** pulses `done` and returns to IDLE.

Top module: `opnd_eval`

## Requirements
- R1: After reset `done`, `rd_req` and `busy` are low.
- R2: Mode 000 (instr[15:13]) gives an operand equal to instr[9:0] with zeros above it. It makes no read, `ea_valid` is low, and `done` comes one cycle after `start`.
- R3: Mode 001 makes one read at instr[9:0]. The operand is the returned word and `eff_addr` is instr[9:0] with `ea_valid` high.
- R4: Mode 010 makes two reads. The first is at instr[9:0]. The second is at bits 9:0 of the first returned word, and the bits above them are ignored. The operand is the second word and `eff_addr` is that pointer.
- R5: Mode 011 makes one read at (instr[9:0] + xr_lo) mod 1024. The operand is the returned word and that sum is `eff_addr`.
- R6: Mode 100 makes one read at (instr[9:0] + sp_lo) mod 1024. The operand is the returned word and that sum is `eff_addr`.
- R7: Modes 101, 110 and 111 set `bad_mode` and make no read. The operand is zero, `ea_valid` is low, and `done` comes one cycle after `start`.
- R8: While `rd_ack` is low, `rd_req` stays high with `rd_addr` unchanged, whatever the latency.
- R9: `done` lasts one cycle. The results stay unchanged until the next accepted `start`, and `start` is ignored while `busy` is high.
- R10: The opcode bits instr[12:10] have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin evaluation; accepted only when idle |
| instr | input | 16 | Current instruction: mode [15:13], opcode [12:10], specifier [9:0] |
| xr_lo | input | 10 | Low bits of the index register |
| sp_lo | input | 10 | Low bits of the stack pointer |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 10 | Memory read address |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | 16 | Read data |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| operand | output | 16 | Resolved operand |
| eff_addr | output | 10 | Effective address for memory modes |
| ea_valid | output | 1 | `eff_addr` is meaningful |
| bad_mode | output | 1 | Mode code was undefined |

## Verification
The hardest case to reach is an indirect access in which the pointer word carries set bits above bit 9 and both reads are stretched by wait states. A second `start` with a different instruction also arrives during the stall. Only then do the pointer truncation, the held request and the refusal of a new start all show at once. The stimulus plants a pointer word with high bits set in the bench memory. It gives the responder a latency of several cycles and pulses `start` again in the cycle after the first one was accepted. Index and stack sums that cross 1023 are driven on purpose to expose the wrap.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    localparam int MODE_W = 3;

    // Decoded addressing kind
    typedef enum logic [2:0] {
        K_IMM,
        K_DIR,
        K_IND,
        K_IDX,
        K_STK,
        K_BAD
    } mode_kind_e;

    // Control states
    typedef enum logic [1:0] {
        S_IDLE,
        S_FETCH_PTR,
        S_FETCH_OPND,
        S_FINISH
    } state_e;

endpackage

// File: rtl/opnd_decode.sv
module opnd_decode
    import opnd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic [DATA_W-1:0] instr,
    output mode_kind_e        kind,
    output logic [ADDR_W-1:0] spec
);
    localparam int MODE_LSB = DATA_W - MODE_W;
    localparam int OPC_W    = MODE_LSB - ADDR_W;

    logic [MODE_W-1:0] mode_bits;
    logic              opcode_unused;

    assign mode_bits     = instr[DATA_W-1:MODE_LSB];
    assign spec          = instr[ADDR_W-1:0];
    assign opcode_unused = ^instr[ADDR_W +: OPC_W];

    always_comb begin
        unique case (mode_bits)
            3'b000:  kind = K_IMM;
            3'b001:  kind = K_DIR;
            3'b010:  kind = K_IND;
            3'b011:  kind = K_IDX;
            3'b100:  kind = K_STK;
            default: kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/opnd_agen.sv
module opnd_agen
    import opnd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  mode_kind_e        kind,
    input  logic [ADDR_W-1:0] spec,
    input  logic [ADDR_W-1:0] xr_lo,
    input  logic [ADDR_W-1:0] sp_lo,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        unique case (kind)
            K_IDX:   offset = xr_lo;
            K_STK:   offset = sp_lo;
            default: offset = '0;
        endcase
    end

    // Sum kept to ADDR_W bits: wraps modulo the address space
    assign addr = spec + offset;

endmodule

// File: rtl/opnd_ctrl.sv
module opnd_ctrl
    import opnd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mode_kind_e        kind,
    input  logic [ADDR_W-1:0] spec,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] operand,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              ea_valid,
    output logic              bad_mode
);
    localparam int EXT_W = DATA_W - ADDR_W;

    state_e            state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] operand_q;
    logic [ADDR_W-1:0] eff_q;
    logic              eav_q;
    logic              bad_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    unique case (kind)
                        K_IMM, K_BAD: state_nx = S_FINISH;
                        K_IND:        state_nx = S_FETCH_PTR;
                        default:      state_nx = S_FETCH_OPND;
                    endcase
                end
            end
            S_FETCH_PTR:  if (rd_ack) state_nx = S_FETCH_OPND;
            S_FETCH_OPND: if (rd_ack) state_nx = S_FINISH;
            S_FINISH:     state_nx = S_IDLE;
            default:      state_nx = S_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        rd_req = 1'b0;
        done   = 1'b0;
        busy   = 1'b1;
        unique case (state)
            S_IDLE:       busy   = 1'b0;
            S_FETCH_PTR:  rd_req = 1'b1;
            S_FETCH_OPND: rd_req = 1'b1;
            S_FINISH:     done   = 1'b1;
            default:      busy   = 1'b0;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            operand_q <= '0;
            eff_q     <= '0;
            eav_q     <= 1'b0;
            bad_q     <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        addr_q    <= first_addr;
                        operand_q <= '0;
                        eff_q     <= '0;
                        eav_q     <= 1'b0;
                        bad_q     <= 1'b0;
                        unique case (kind)
                            K_IMM: operand_q <= {{EXT_W{1'b0}}, spec};
                            K_BAD: bad_q     <= 1'b1;
                            K_IND: ;
                            default: begin
                                eff_q <= first_addr;
                                eav_q <= 1'b1;
                            end
                        endcase
                    end
                end
                S_FETCH_PTR: begin
                    if (rd_ack) begin
                        addr_q <= rd_data[ADDR_W-1:0];
                        eff_q  <= rd_data[ADDR_W-1:0];
                        eav_q  <= 1'b1;
                    end
                end
                S_FETCH_OPND: begin
                    if (rd_ack) operand_q <= rd_data;
                end
                default: ;
            endcase
        end
    end

    assign rd_addr  = addr_q;
    assign operand  = operand_q;
    assign eff_addr = eff_q;
    assign ea_valid = eav_q;
    assign bad_mode = bad_q;

endmodule

// File: rtl/opnd_eval.sv
module opnd_eval
    import opnd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] instr,
    input  logic [ADDR_W-1:0] xr_lo,
    input  logic [ADDR_W-1:0] sp_lo,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] operand,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              ea_valid,
    output logic              bad_mode
);
    mode_kind_e        kind;
    logic [ADDR_W-1:0] spec;
    logic [ADDR_W-1:0] first_addr;

    opnd_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
        .instr (instr),
        .kind  (kind),
        .spec  (spec)
    );

    opnd_agen #(.ADDR_W(ADDR_W)) u_agen (
        .kind  (kind),
        .spec  (spec),
        .xr_lo (xr_lo),
        .sp_lo (sp_lo),
        .addr  (first_addr)
    );

    opnd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .kind       (kind),
        .spec       (spec),
        .first_addr (first_addr),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .busy       (busy),
        .done       (done),
        .operand    (operand),
        .eff_addr   (eff_addr),
        .ea_valid   (ea_valid),
        .bad_mode   (bad_mode)
    );

endmodule

// File: rtl/opnd_eval_chk.sv
module opnd_eval_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] instr,
    input logic [ADDR_W-1:0] xr_lo,
    input logic [ADDR_W-1:0] sp_lo,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] operand,
    input logic              bad_mode
);
    localparam int MODE_LSB = DATA_W - 3;
    localparam int EXT_W    = DATA_W - ADDR_W;

    logic       go;
    logic [2:0] md;
    assign go = start && !busy;
    assign md = instr[DATA_W-1:MODE_LSB];

    assert_imm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go && md == 3'b000 |=> done && !rd_req &&
            operand == {{EXT_W{1'b0}}, $past(instr[ADDR_W-1:0])});

    assert_direct_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go && md == 3'b001 |=> rd_req && rd_addr == $past(instr[ADDR_W-1:0]));

    assert_ptr_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        go && md == 3'b010 |=> rd_req && rd_addr == $past(instr[ADDR_W-1:0]));

    assert_index_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        go && md == 3'b011 |=> rd_req &&
            rd_addr == ADDR_W'($past(instr[ADDR_W-1:0]) + $past(xr_lo)));

    assert_stack_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        go && md == 3'b100 |=> rd_req &&
            rd_addr == ADDR_W'($past(instr[ADDR_W-1:0]) + $past(sp_lo)));

    assert_illegal_noread_R7: assert property (@(posedge clk) disable iff (!rst_n)
        go && md > 3'b100 |=> done && !rd_req && bad_mode);

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind opnd_eval opnd_eval_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .instr    (instr),
    .xr_lo    (xr_lo),
    .sp_lo    (sp_lo),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_ack   (rd_ack),
    .busy     (busy),
    .done     (done),
    .operand  (operand),
    .bad_mode (bad_mode)
);

// File: tb/tb_opnd_eval.sv
module tb_opnd_eval;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [9:0]  xr_lo = '0;
    logic [9:0]  sp_lo = '0;
    logic        rd_req;
    logic [9:0]  rd_addr;
    logic        rd_ack = 1'b0;
    logic [15:0] rd_data = '0;
    logic        busy, done, ea_valid, bad_mode;
    logic [15:0] operand;
    logic [9:0]  eff_addr;

    always #10 clk = ~clk;   // 50 MHz

    opnd_eval dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .xr_lo(xr_lo), .sp_lo(sp_lo), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy), .done(done),
        .operand(operand), .eff_addr(eff_addr), .ea_valid(ea_valid),
        .bad_mode(bad_mode)
    );

    typedef struct {
        logic [15:0] op;
        logic [9:0]  ea;
        logic        eav;
        logic        bad;
        int          nrd;
        logic [9:0]  a0;
        logic [9:0]  a1;
    } exp_t;

    logic [15:0] mem [0:1023];
    exp_t        expq[$];
    string       tagq[$];
    logic [9:0]  rdlog[$];
    int          latency = 0;
    int          checks = 0;
    int          fails = 0;
    bit          finished = 0;
    logic        prev_done = 1'b0;
    logic [15:0] last_op;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [15:0] ins, input logic [9:0] x, input logic [9:0] s);
        exp_t e;
        logic [9:0] sv, a;
        sv = ins[9:0];
        e = '{op: '0, ea: '0, eav: 1'b0, bad: 1'b0, nrd: 0, a0: '0, a1: '0};
        case (ins[15:13])
            3'b000: e.op = {6'b0, sv};
            3'b001: begin e.op = mem[sv]; e.ea = sv; e.eav = 1; e.nrd = 1; e.a0 = sv; end
            3'b010: begin
                a = mem[sv][9:0];
                e.op = mem[a]; e.ea = a; e.eav = 1; e.nrd = 2; e.a0 = sv; e.a1 = a;
            end
            3'b011: begin a = sv + x; e.op = mem[a]; e.ea = a; e.eav = 1; e.nrd = 1; e.a0 = a; end
            3'b100: begin a = sv + s; e.op = mem[a]; e.ea = a; e.eav = 1; e.nrd = 1; e.a0 = a; end
            default: e.bad = 1;
        endcase
        return e;
    endfunction

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'b000:  return "R2";
            3'b001:  return "R3";
            3'b010:  return "R4";
            3'b011:  return "R5";
            3'b100:  return "R6";
            default: return "R7";
        endcase
    endfunction

    // Driver: pushes the expectation, pulses start, optionally pokes start mid-flight
    task automatic issue(input logic [15:0] ins, input logic [9:0] x, input logic [9:0] s,
                         input int lat, input bit poke);
        expq.push_back(model(ins, x, s));
        tagq.push_back(tag_of(ins[15:13]));
        latency = lat;
        @(negedge clk);
        instr = ins; xr_lo = x; sp_lo = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            instr = ~ins; xr_lo = ~x; sp_lo = ~s; start = 1'b1;   // R9: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        last_op = operand;
    endtask

    // Memory responder with programmable wait states
    initial begin
        int waitc = 0;
        forever begin
            @(negedge clk);
            if (rd_ack) begin
                rd_ack = 1'b0;
            end else if (rst_n && rd_req) begin
                if (waitc >= latency) begin
                    rd_ack  = 1'b1;
                    rd_data = mem[rd_addr];
                    rdlog.push_back(rd_addr);
                    waitc = 0;
                end else begin
                    waitc++;
                end
            end
        end
    end

    // Monitor: pops the scoreboard on each done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                chk("R9 done single cycle", {31'b0, prev_done}, 32'd0);
                if (expq.size() == 0) begin
                    chk("R9 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t  e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    chk({t, " operand"}, {16'b0, operand}, {16'b0, e.op});
                    chk({t, " ea_valid"}, {31'b0, ea_valid}, {31'b0, e.eav});
                    chk({t, " bad_mode"}, {31'b0, bad_mode}, {31'b0, e.bad});
                    if (e.eav) chk({t, " eff_addr"}, {22'b0, eff_addr}, {22'b0, e.ea});
                    chk({t, " read count"}, rdlog.size(), e.nrd);
                    if (rdlog.size() == e.nrd) begin
                        if (e.nrd >= 1) chk({t, " first read addr"}, {22'b0, rdlog[0]}, {22'b0, e.a0});
                        if (e.nrd == 2) chk({t, " second read addr"}, {22'b0, rdlog[1]}, {22'b0, e.a1});
                    end
                    rdlog.delete();
                end
            end
            prev_done = done;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] lcg;
        for (int i = 0; i < 1024; i++) mem[i] = 16'((i * 40503) ^ 16'hA5C3);
        mem[10'h005] = 16'hFC21;           // pointer with high bits set (R4)
        mem[10'h021] = 16'h1234;
        mem[10'h3FF] = 16'hBEEF;
        mem[10'h000] = 16'h0F0F;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 rd_req", {31'b0, rd_req}, 32'd0);
        chk("R1 busy", {31'b0, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 immediate, opcode bits set (R10)
        issue({3'b000, 3'b111, 10'h3FF}, 10'h155, 10'h2AA, 0, 0);
        issue({3'b000, 3'b000, 10'h000}, 10'h000, 10'h000, 0, 0);
        // R3 direct, zero and stretched latency; R10 opcode variants
        issue({3'b001, 3'b000, 10'h123}, 10'h000, 10'h000, 0, 0);
        issue({3'b001, 3'b111, 10'h123}, 10'h3FF, 10'h3FF, 3, 0);
        // R4 indirect with pointer high bits set, stalls, start poked mid-flight (R8, R9)
        issue({3'b010, 3'b101, 10'h005}, 10'h000, 10'h000, 4, 1);
        // R9: outputs stay put after done
        repeat (3) @(negedge clk);
        chk("R9 operand held", {16'b0, operand}, {16'b0, last_op});
        chk("R9 eff_addr held", {22'b0, eff_addr}, 32'h021);
        // R5 indexed with wrap
        issue({3'b011, 3'b010, 10'h3F0}, 10'h020, 10'h000, 1, 0);
        // R6 stack, no wrap and wrap to zero
        issue({3'b100, 3'b001, 10'h200}, 10'h000, 10'h1FF, 2, 0);
        issue({3'b100, 3'b001, 10'h3FF}, 10'h000, 10'h001, 0, 0);
        // R7 illegal codes
        issue({3'b101, 3'b000, 10'h011}, 10'h001, 10'h001, 0, 0);
        issue({3'b110, 3'b011, 10'h3FF}, 10'h001, 10'h001, 0, 0);
        issue({3'b111, 3'b111, 10'h200}, 10'h001, 10'h001, 0, 0);
        // Mixed sweep
        lcg = 32'h1357_9BDF;
        for (int i = 0; i < 40; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            issue(lcg[31:16], lcg[9:0], lcg[19:10], i % 4, (i % 5) == 0);
        end
        repeat (3) @(negedge clk);
        chk("R9 no pending results", expq.size(), 0);
        finish_run();
    end

endmodule